// File: doc/BRIEF.md
# ECC Write Merge and Check-Bit Generator

This block sits in the write path of a memory controller that protects each stored word with a single-error-correct, double-error-detect code. Each cycle it may take one write word and produce a codeword: the data word with eight check bits attached above it. The codeword appears one registered stage later. The controller must therefore fetch write data one cycle earlier, relative to the write command, than it would without the code.

Partial writes are done as read-modify-write. The controller first reads the target word and corrects it, then presents it as the old data, together with the new bytes and a byte mask. It raises the merge select for these writes. The block builds the merged word and computes the check bits on that merged word, all in the same stage. When the merge select is low, it is a full write: the mask and the old data play no part.

The check bits use a fixed Hamming layout plus an overall parity bit. The decode side must use the same matrix.

Top module: `ecc_wr_merge_gen`

## Requirements
- R1: On the first rising edge with `rst_n` low, and for as long as it stays low, `out_valid` is 0 and `out_code` is all zeros.
- R2: `out_valid` equals `in_valid` from the previous rising edge, so the latency is exactly one cycle.
- R3: A word taken with `merge_en` low gives `out_code[63:0]` equal to `wr_data`, whatever `wr_mask` and `old_data` hold.
- R4: A word taken with `merge_en` high builds `out_code[63:0]` byte by byte. Byte b (bits 8b+7..8b) comes from `old_data` when `wr_mask[b]` is 1, and from `wr_data` when it is 0.
- R5: Number the integers from 1 upward. Data bit i goes to the (i+1)-th integer that is not a power of two (bit 0 at 3, bit 1 at 5, bit 2 at 6, ...). `out_code[64+k]`, for k = 0..6, is bit k of the XOR of the positions of all data bits that are 1.
- R6: `out_code[71]` makes the XOR of all 72 bits of `out_code` equal to 0.
- R7: On an edge where `in_valid` is low, `out_code` keeps its previous value.
- R8: The codeword layout puts the merged data word in `out_code[63:0]` and the check bits in `out_code[71:64]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A write word is presented this cycle |
| wr_data | input | 64 | New write data |
| wr_mask | input | 8 | Per byte: 1 keeps the old byte, 0 takes the new byte (merge only) |
| old_data | input | 64 | Corrected read-back word for read-modify-write |
| merge_en | input | 1 | 1 selects merge under the mask, 0 selects a full write |
| out_valid | output | 1 | Codeword valid, one cycle after `in_valid` |
| out_code | output | 72 | Check bits [71:64] over data [63:0] |

## Verification
The bench drives full writes with a mask of all ones and old data that differs from the new data. A design that let the mask act outside merge mode would return old bytes there. Merge writes use masks of all zeros, all ones and mixed bytes, so a byte lane that is swapped or inverted shows up as a wrong byte. Single-bit data words at both ends and in the middle catch a mistake in where data bits sit in the code: such a design would give a wrong syndrome in bits 64..70. Gaps with `in_valid` low sit between words, so a register that loads every cycle would change the codeword, and a wrong delay would shift `out_valid` against the expected stream.

// File: rtl/ecc_wr_pkg.sv
// Package ecc_wr_pkg
// Shared sizes and a helper for the ECC write path.
// Assumes byte-sized mask lanes and a Hamming code extended by one parity bit.
package ecc_wr_pkg;
    localparam int DEF_DATA_W = 64;
    localparam int DEF_BYTE_W = 8;

    // Smallest r with 2**r >= dw + r + 1 (Hamming check-bit count).
    function automatic int ham_bits(input int dw);
        int r;
        r = 1;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction
endpackage

// File: rtl/ecc_byte_merge.sv
// Module ecc_byte_merge
// Builds the word that gets protected. In merge mode each byte lane takes
// the old byte when its mask bit is set, and the new byte when it is clear.
// In full-write mode every lane takes the new byte.
// Assumes DATA_W is a whole multiple of BYTE_W.
module ecc_byte_merge #(
    parameter int DATA_W = 64,
    parameter int BYTE_W = 8,
    localparam int NLANE = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] new_word,
    input  logic [DATA_W-1:0] prev_word,
    input  logic [NLANE-1:0]  keep_lane,
    input  logic              rmw_sel,
    output logic [DATA_W-1:0] merged_word
);
    for (genvar b = 0; b < NLANE; b++) begin : g_lane
        // Lane select: keep the old byte only in merge mode with the mask bit set.
        assign merged_word[b*BYTE_W +: BYTE_W] =
            (rmw_sel && keep_lane[b]) ? prev_word[b*BYTE_W +: BYTE_W]
                                      : new_word[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/ecc_check_gen.sv
// Module ecc_check_gen
// Combinational check bits for a SECDED code. Data bits take, in order,
// the integer positions that are not powers of two, starting at 3.
// Hamming bit k is the XOR of the data bits whose position has bit k set.
// The top bit is even parity over the data and the Hamming bits.
// Assumes HAM_W is large enough for DATA_W (see ecc_wr_pkg::ham_bits).
module ecc_check_gen #(
    parameter int DATA_W = 64,
    parameter int HAM_W  = 7,
    localparam int CHK_W = HAM_W + 1
) (
    input  logic [DATA_W-1:0] word,
    output logic [CHK_W-1:0]  chk
);
    // Coverage mask of Hamming bit k, worked out at elaboration.
    function automatic logic [DATA_W-1:0] cover_mask(input int k);
        logic [DATA_W-1:0] m;
        int idx;
        m   = '0;
        idx = 0;
        for (int pos = 1; pos < (1 << HAM_W); pos++) begin
            if ((pos & (pos - 1)) != 0 && idx < DATA_W) begin
                if (((pos >> k) & 1) == 1) m[idx] = 1'b1;
                idx++;
            end
        end
        return m;
    endfunction

    logic [HAM_W-1:0] ham;

    for (genvar k = 0; k < HAM_W; k++) begin : g_ham
        localparam logic [DATA_W-1:0] COVER = cover_mask(k);
        // Parity over the data bits that Hamming bit k covers.
        assign ham[k] = ^(word & COVER);
    end

    // Overall parity bit on top of the Hamming bits.
    assign chk = {(^word) ^ (^ham), ham};
endmodule

// File: rtl/ecc_wr_merge_gen.sv
// Module ecc_wr_merge_gen (top)
// One registered stage: merges new bytes into the corrected old word
// (read-modify-write) or passes the new word (full write). It then appends
// the SECDED check bits computed on the result. out_valid follows in_valid
// by one cycle. The codeword register loads only on valid input.
// Assumes the old word is already corrected and lined up with in_valid.
module ecc_wr_merge_gen
    import ecc_wr_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int NLANE  = DATA_W / BYTE_W,
    localparam int HAM_W  = ham_bits(DATA_W),
    localparam int CHK_W  = HAM_W + 1,
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NLANE-1:0]  wr_mask,
    input  logic [DATA_W-1:0] old_data,
    input  logic              merge_en,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code
);
    logic [DATA_W-1:0] merged;
    logic [CHK_W-1:0]  chk_bits;

    ecc_byte_merge #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_merge (
        .new_word    (wr_data),
        .prev_word   (old_data),
        .keep_lane   (wr_mask),
        .rmw_sel     (merge_en),
        .merged_word (merged)
    );

    ecc_check_gen #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_gen (
        .word (merged),
        .chk  (chk_bits)
    );

    // Output stage: register valid every cycle, load the codeword on valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_code <= {chk_bits, merged};
        end
    end
endmodule

// File: rtl/ecc_wr_merge_gen_chk.sv
// Module ecc_wr_merge_gen_chk
// Property checker for ecc_wr_merge_gen, attached with bind.
// Assumes the default 64-bit data word and byte lanes.
module ecc_wr_merge_gen_chk #(
    parameter int DATA_W = 64,
    parameter int BYTE_W = 8,
    parameter int CODE_W = 72,
    localparam int NLANE = DATA_W / BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] wr_data,
    input logic [NLANE-1:0]  wr_mask,
    input logic [DATA_W-1:0] old_data,
    input logic              merge_en,
    input logic              out_valid,
    input logic [CODE_W-1:0] out_code
);
    logic [DATA_W-1:0] lane_keep;

    // Expands the byte mask to bit level for the merge property.
    always_comb begin
        for (int b = 0; b < NLANE; b++)
            lane_keep[b*BYTE_W +: BYTE_W] = {BYTE_W{wr_mask[b]}};
    end

    // R2: valid out follows valid in after one edge
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3: full write carries the new word unchanged
    a_r3_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !merge_en) |=> (out_code[DATA_W-1:0] == $past(wr_data)));
    // R4: merge takes masked lanes from the old word
    a_r4_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && merge_en) |=>
        (out_code[DATA_W-1:0] == $past((old_data & lane_keep) | (wr_data & ~lane_keep))));
    // R6: codeword has even overall parity
    a_r6_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (^out_code == 1'b0));
    // R7: codeword holds while no input is valid
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_code));
endmodule

bind ecc_wr_merge_gen ecc_wr_merge_gen_chk #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .CODE_W(CODE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wr_data(wr_data),
    .wr_mask(wr_mask), .old_data(old_data), .merge_en(merge_en),
    .out_valid(out_valid), .out_code(out_code)
);

// File: tb/ecc_wr_merge_gen_test.sv
// Scoreboard bench for ecc_wr_merge_gen: the driver queues expected
// results, and the monitor pops and compares them after each edge.
module ecc_wr_merge_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] wr_data = '0;
    logic [7:0]  wr_mask = '0;
    logic [63:0] old_data = '0;
    logic        merge_en = 1'b0;
    logic        out_valid;
    logic [71:0] out_code;

    int tests = 0;
    int fails = 0;
    bit mon_on = 1'b0;

    typedef struct {
        logic        vld;
        logic [71:0] code;
        int          kind; // 0 full, 1 merge, 2 idle
    } exp_t;
    exp_t q[$];
    logic [71:0] last_code = '0;

    ecc_wr_merge_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wr_data(wr_data),
        .wr_mask(wr_mask), .old_data(old_data), .merge_en(merge_en),
        .out_valid(out_valid), .out_code(out_code)
    );

    always #4 clk = ~clk;

    // Reference codeword: the syndrome is the XOR of the positions of set data bits.
    function automatic logic [71:0] ref_code(input logic [63:0] d);
        logic [6:0] syn;
        int idx;
        syn = '0;
        idx = 0;
        for (int pos = 3; idx < 64; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (d[idx]) syn ^= pos[6:0];
                idx++;
            end
        end
        return {(^d) ^ (^syn), syn, d};
    endfunction

    task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [63:0] wd, input logic [7:0] m,
                         input logic [63:0] od, input logic me);
        exp_t e;
        logic [63:0] merged;
        @(negedge clk);
        in_valid = v; wr_data = wd; wr_mask = m; old_data = od; merge_en = me;
        for (int b = 0; b < 8; b++)
            merged[b*8 +: 8] = (me && m[b]) ? od[b*8 +: 8] : wd[b*8 +: 8];
        if (v) last_code = ref_code(merged);
        e.vld = v; e.code = last_code; e.kind = !v ? 2 : (me ? 1 : 0);
        q.push_back(e);
    endtask

    // Monitor: after each edge, compare against the oldest expected item.
    always @(posedge clk) begin
        #2;
        if (mon_on && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check("R2 valid delay", {71'd0, out_valid}, {71'd0, e.vld});
            if (e.kind == 2)
                check("R7 hold on idle", out_code, e.code);
            else begin
                check(e.kind == 1 ? "R4 R8 merged data" : "R3 R8 full data",
                      {8'd0, out_code[63:0]}, {8'd0, e.code[63:0]});
                check("R5 hamming bits", {65'd0, out_code[70:64]}, {65'd0, e.code[70:64]});
                check("R6 overall parity", {71'd0, out_code[71]}, {71'd0, e.code[71]});
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        fails++; tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset clears outputs even with valid input present
        in_valid = 1'b1; wr_data = 64'hDEAD_BEEF_1234_5678;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", {71'd0, out_valid}, 72'd0);
        check("R1 reset code", out_code, 72'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        mon_on = 1'b1;
        last_code = '0;

        // R3: full writes; mask and old data must not matter
        drive(1, 64'h0, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 64'h0, 0);
        drive(1, 64'hA5A5_5A5A_0F0F_F0F0, 8'h5A, 64'h1111_2222_3333_4444, 0);
        // R5: single-bit words exercise bit positions
        drive(1, 64'h1, 8'h00, 64'h0, 0);
        drive(1, 64'h2, 8'h00, 64'h0, 0);
        drive(1, 64'h8000_0000_0000_0000, 8'h00, 64'h0, 0);
        drive(1, 64'h0000_0001_0000_0000, 8'h00, 64'h0, 0);
        // R7: idle gap keeps the last codeword
        drive(0, 64'h1357_9BDF_2468_ACE0, 8'h00, 64'h0, 1);
        drive(0, 64'hFFFF_0000_FFFF_0000, 8'hFF, 64'h1, 0);
        // R4: merge with assorted masks
        drive(1, 64'h0123_4567_89AB_CDEF, 8'h00, 64'hFEDC_BA98_7654_3210, 1);
        drive(1, 64'h0123_4567_89AB_CDEF, 8'hFF, 64'hFEDC_BA98_7654_3210, 1);
        drive(1, 64'h0123_4567_89AB_CDEF, 8'h5A, 64'hFEDC_BA98_7654_3210, 1);
        drive(1, 64'hAAAA_AAAA_AAAA_AAAA, 8'h81, 64'h5555_5555_5555_5555, 1);
        drive(0, 64'h0, 8'h00, 64'h0, 0);
        drive(1, 64'h0, 8'h01, 64'hFFFF_FFFF_FFFF_FFFF, 1);
        // Mixed stream with pseudo-random words
        for (int i = 0; i < 40; i++) begin
            drive(i % 5 != 4, {$urandom, $urandom}, 8'($urandom), {$urandom, $urandom}, 1'(i % 2));
        end
        drive(0, 64'h0, 8'h00, 64'h0, 0);
        drive(0, 64'h0, 8'h00, 64'h0, 0);
        repeat (3) @(posedge clk);
        #3;
        check("R2 scoreboard drained", {40'd0, 32'(q.size())}, 72'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule